// File: doc/BRIEF.md
# DMA Byte-Enable Generator

This block walks one memory region a DWORD at a time and produces the byte-lane enables for each bus beat. A region is loaded with a start pulse. The pulse carries the region's half-word start address, its byte count and a direction flag. The direction is either a read from memory or a write to memory. The block then presents one beat per cycle on a valid/ready handshake. It moves on only when the bus side accepts the beat, and it raises a one-cycle done pulse once the region is used up.

Reads ignore the half-word offset of the start address and fetch whole DWORDs, so every lane is on. Writes keep the offset: a start in the upper half of a DWORD switches off the two low lanes of the first beat. Lanes beyond the last valid byte are cleared on the final beat. Writes are framed as 32-byte line bursts of eight beats, with start and end markers. A region that does not start on a line boundary gets a short first burst that ends at the next boundary. Reads are framed as one continuous burst.

The controller has four states: IDLE, READ, WRITE and DONE. IDLE moves to READ or WRITE on a start pulse, according to the direction flag. READ and WRITE stay put until the final beat is accepted, then move to DONE. DONE always returns to IDLE on the next cycle.

Top module: `dma_be_gen`

## Requirements
- R1: After reset the block is idle: beat_valid, busy and done are all 0.
- R2: On a read, beat_be is 4'b1111 on every beat. The first beat address is the start address with bits 1:0 cleared. The region takes ceil(count/4) beats.
- R3: On a write whose start address has bit 1 set, lanes 1:0 of the first beat are off. With at least two bytes the first mask is 4'b1100; with one byte it is 4'b0100.
- R4: On a write, the enabled lanes add up over all beats to exactly the byte count. On the final beat, lanes past the last valid byte are off. Bit i of beat_be is byte lane i, and lane 0 is the least significant byte. No beat ever has an all-zero mask.
- R5: On a write, burst_start is high on the first beat and on every beat whose address has bits 4:2 equal to 0. burst_end is high on the last beat and on every beat whose address has bits 4:2 equal to 7. On a read, burst_start marks only the first beat and burst_end marks only the last.
- R6: A beat is consumed only when beat_valid and beat_ready are both high. While ready is low, beat_addr and beat_be hold.
- R7: done is high for exactly one cycle, the cycle after the final beat is accepted. In that cycle beat_valid is 0, and the block is idle on the next cycle.
- R8: A start pulse while busy is high is ignored. The running region completes unchanged.
- R9: A byte count of 0 stands for 2^CNT_W bytes (65536 by default).
- R10: Each accepted beat advances beat_addr by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new region (taken only when idle) |
| start_addr | input | ADDR_W-1 | Region start address, bits ADDR_W-1:1 |
| start_count | input | CNT_W | Region byte count, 0 means 2^CNT_W |
| start_write | input | 1 | 1 = write to memory, 0 = read from memory |
| beat_ready | input | 1 | Bus side accepts the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_addr | output | ADDR_W | DWORD-aligned byte address of the beat |
| beat_be | output | 4 | Active-high byte-lane enables |
| burst_start | output | 1 | Beat opens a burst |
| burst_end | output | 1 | Beat closes a burst |
| busy | output | 1 | A region is loaded and not yet finished |
| done | output | 1 | One-cycle pulse after the final beat |

## Verification
The assertions check several behaviours on every cycle. They check full lanes on reads and DWORD-aligned beat addresses. They check that beat_addr and beat_be hold under back-pressure and that the address steps by 4 after each acceptance. They also check the line-end marker at offset 28, that no beat is empty, and that done lasts one cycle and leaves the block idle. Other behaviours only the bench's scenarios can show. These include the exact first and last lane masks, the beat counts, and the byte totals of a write. They also include the number of bursts for aligned and unaligned starts, a start pulse ignored in mid-region, and the full 64 KiB region coded as a zero count.

// File: rtl/dma_be_pkg.sv
package dma_be_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } be_state_e;

    localparam int LANES = 4;

endpackage

// File: rtl/dma_be_lane_mask.sv
module dma_be_lane_mask #(
    parameter int CNT_W = 16
) (
    input  logic             upper_half,
    input  logic [CNT_W:0]   remaining,
    output logic [3:0]       lane_be,
    output logic [2:0]       lane_bytes
);
    // lanes available in this DWORD from the first valid lane upward
    logic [2:0] avail;
    logic [1:0] low_lane;
    logic [4:0] run;

    always_comb begin
        avail    = upper_half ? 3'd2 : 3'd4;
        low_lane = upper_half ? 2'd2 : 2'd0;
        if (remaining < (CNT_W+1)'(avail)) begin
            lane_bytes = remaining[2:0];
        end else begin
            lane_bytes = avail;
        end
        run     = (5'd1 << lane_bytes) - 5'd1;
        lane_be = run[3:0] << low_lane;
    end

endmodule

// File: rtl/dma_be_line_pos.sv
module dma_be_line_pos #(
    parameter int LINE_DW_W = 3
) (
    input  logic                 write_mode,
    input  logic                 first_beat,
    input  logic                 last_beat,
    input  logic [LINE_DW_W-1:0] dw_index,
    output logic                 opens,
    output logic                 closes
);
    always_comb begin
        if (write_mode) begin
            opens  = first_beat || (dw_index == '0);
            closes = last_beat  || (dw_index == '1);
        end else begin
            opens  = first_beat;
            closes = last_beat;
        end
    end

endmodule

// File: rtl/dma_be_gen.sv
module dma_be_gen #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:1] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              start_write,
    input  logic              beat_ready,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [3:0]        beat_be,
    output logic              burst_start,
    output logic              burst_end,
    output logic              busy,
    output logic              done
);
    import dma_be_pkg::*;

    localparam int LINE_DW   = LINE_BYTES / LANES;
    localparam int LINE_DW_W = $clog2(LINE_DW);
    localparam int DWA_W     = ADDR_W - 2;

    be_state_e        state_q, state_d;
    logic [DWA_W-1:0] dw_addr_q;
    logic             half_q;
    logic [CNT_W:0]   rem_q;
    logic             first_q;

    logic [3:0]       mask_be;
    logic [2:0]       mask_bytes;
    logic             final_beat;
    logic             accept;
    logic             open_w, close_w;

    dma_be_lane_mask #(.CNT_W(CNT_W)) i_mask (
        .upper_half (half_q),
        .remaining  (rem_q),
        .lane_be    (mask_be),
        .lane_bytes (mask_bytes)
    );

    dma_be_line_pos #(.LINE_DW_W(LINE_DW_W)) i_line (
        .write_mode (state_q == ST_WRITE),
        .first_beat (first_q),
        .last_beat  (final_beat),
        .dw_index   (dw_addr_q[LINE_DW_W-1:0]),
        .opens      (open_w),
        .closes     (close_w)
    );

    assign final_beat = (rem_q == (CNT_W+1)'(mask_bytes));
    assign accept     = beat_valid && beat_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = start_write ? ST_WRITE : ST_READ;
            ST_READ,
            ST_WRITE: if (accept && final_beat) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // region walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dw_addr_q <= '0;
            half_q    <= 1'b0;
            rem_q     <= '0;
            first_q   <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            dw_addr_q <= start_addr[ADDR_W-1:2];
            half_q    <= start_write && start_addr[1];
            rem_q     <= (start_count == '0) ? {1'b1, {CNT_W{1'b0}}}
                                             : {1'b0, start_count};
            first_q   <= 1'b1;
        end else if (accept) begin
            dw_addr_q <= dw_addr_q + DWA_W'(1);
            half_q    <= 1'b0;
            rem_q     <= rem_q - (CNT_W+1)'(mask_bytes);
            first_q   <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        beat_valid = 1'b0;
        beat_be    = 4'b0000;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_READ:  begin beat_valid = 1'b1; beat_be = 4'b1111; end
            ST_WRITE: begin beat_valid = 1'b1; beat_be = mask_be; end
            ST_DONE:  done = 1'b1;
        endcase
        beat_addr   = {dw_addr_q, 2'b00};
        burst_start = beat_valid && open_w;
        burst_end   = beat_valid && close_w;
    end

endmodule

// File: rtl/dma_be_gen_chk.sv
module dma_be_gen_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  beat_valid,
    input logic                  beat_ready,
    input logic [ADDR_W-1:0]     beat_addr,
    input logic [3:0]            beat_be,
    input logic                  burst_end,
    input logic                  busy,
    input logic                  done,
    input dma_be_pkg::be_state_e state_q
);
    localparam int LINE_MSB = $clog2(LINE_BYTES) - 1;

    assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == dma_be_pkg::ST_READ) |-> (beat_be == 4'b1111));

    assert_dword_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_addr[1:0] == 2'b00));

    assert_lanes_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_be != 4'b0000));

    assert_line_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == dma_be_pkg::ST_WRITE) && (beat_addr[LINE_MSB:2] == '1))
        |-> burst_end);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready)
        |=> (beat_valid && $stable(beat_addr) && $stable(beat_be)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_no_beat_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid);

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready)
        |=> (!beat_valid || (beat_addr == $past(beat_addr) + ADDR_W'(4))));

endmodule

bind dma_be_gen dma_be_gen_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_be    (beat_be),
    .burst_end  (burst_end),
    .busy       (busy),
    .done       (done),
    .state_q    (state_q)
);

// File: tb/test_dma_be_gen.sv
module test_dma_be_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] addr_full = '0;
    logic [15:0] start_count = '0;
    logic        start_write = 1'b0;
    logic        beat_ready = 1'b0;
    logic        beat_valid;
    logic [31:0] beat_addr;
    logic [3:0]  beat_be;
    logic        burst_start, burst_end, busy, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_be_gen i_dma_be_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_addr(addr_full[31:1]), .start_count(start_count),
        .start_write(start_write), .beat_ready(beat_ready),
        .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_be(beat_be),
        .burst_start(burst_start), .burst_end(burst_end),
        .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [15:0] cnt;
        logic [15:0] beats;
        logic [3:0]  fbe;
        logic [3:0]  lbe;
        logic [31:0] faddr;
        logic [3:0]  bursts;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'h1000, 16'd32, 16'd8,  4'hF, 4'hF, 32'h1000, 4'd1},
        '{1'b1, 32'h1002, 16'd5,  16'd2,  4'hC, 4'h7, 32'h1000, 4'd1},
        '{1'b1, 32'h1004, 16'd1,  16'd1,  4'h1, 4'h1, 32'h1004, 4'd1},
        '{1'b1, 32'h1006, 16'd1,  16'd1,  4'h4, 4'h4, 32'h1004, 4'd1},
        '{1'b1, 32'h1010, 16'd40, 16'd10, 4'hF, 4'hF, 32'h1010, 4'd2},
        '{1'b1, 32'h101A, 16'd9,  16'd3,  4'hC, 4'h7, 32'h1018, 4'd2},
        '{1'b0, 32'h2002, 16'd5,  16'd2,  4'hF, 4'hF, 32'h2000, 4'd1},
        '{1'b0, 32'h2000, 16'd1,  16'd1,  4'hF, 4'hF, 32'h2000, 4'd1},
        '{1'b0, 32'h2004, 16'd64, 16'd16, 4'hF, 4'hF, 32'h2004, 4'd1},
        '{1'b1, 32'h3000, 16'd6,  16'd2,  4'hF, 4'h3, 32'h3000, 4'd1}
    };

    // results of one region run
    int          n_beats, n_sop, n_eop, byte_sum, last_acc, done_cyc, done_cnt;
    logic [3:0]  fbe, lbe;
    logic [31:0] faddr, laddr;

    task automatic run_region(input logic wr, input logic [31:0] a,
                              input logic [15:0] c, input int stall,
                              input int kick_at);
        int cyc;
        n_beats = 0; n_sop = 0; n_eop = 0; byte_sum = 0;
        last_acc = -1; done_cyc = -1; done_cnt = 0;
        fbe = '0; lbe = '0; faddr = '0; laddr = '0;
        @(negedge clk);
        start = 1'b1; start_write = wr; addr_full = a; start_count = c;
        cyc = 0;
        while (cyc < 100000) begin
            @(negedge clk);
            start = (cyc == kick_at);
            if (start) begin
                start_write = 1'b0; addr_full = 32'h5000; start_count = 16'd4;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
                break;
            end
            if (beat_valid) begin
                beat_ready = (stall == 0) || (cyc % 2 == 1);
                if (beat_ready) begin
                    if (n_beats == 0) begin fbe = beat_be; faddr = beat_addr; end
                    lbe = beat_be; laddr = beat_addr;
                    n_beats++;
                    byte_sum += $countones(beat_be);
                    if (burst_start) n_sop++;
                    if (burst_end)   n_eop++;
                    last_acc = cyc;
                end
            end else begin
                beat_ready = 1'b0;
            end
            cyc++;
        end
        start = 1'b0;
        beat_ready = 1'b0;
        @(negedge clk);
        if (done) done_cnt++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "beat_valid in reset", beat_valid, 0);
        chk("R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "beat_valid after reset", beat_valid, 0);
        chk("R1", "done after reset", done, 0);
        chk("R1", "busy after reset", busy, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_region(VECS[i].wr, VECS[i].addr, VECS[i].cnt, i % 2, -1);
            chk(VECS[i].wr ? "R4" : "R2", $sformatf("v%0d beats", i), n_beats, VECS[i].beats);
            chk(VECS[i].wr ? "R3" : "R2", $sformatf("v%0d first be", i), fbe, VECS[i].fbe);
            chk("R4", $sformatf("v%0d last be", i), lbe, VECS[i].lbe);
            chk("R2", $sformatf("v%0d first addr", i), faddr, VECS[i].faddr);
            chk("R10", $sformatf("v%0d last addr", i), laddr,
                VECS[i].faddr + 4 * (VECS[i].beats - 1));
            chk("R5", $sformatf("v%0d burst starts", i), n_sop, VECS[i].bursts);
            chk("R5", $sformatf("v%0d burst ends", i), n_eop, VECS[i].bursts);
            chk("R7", $sformatf("v%0d done lag", i), done_cyc - last_acc, 1);
            chk("R7", $sformatf("v%0d done width", i), done_cnt, 1);
            if (VECS[i].wr) chk("R4", $sformatf("v%0d byte sum", i), byte_sum, VECS[i].cnt);
        end

        // R6 stall hold: beat must not move while ready is low
        @(negedge clk);
        start = 1'b1; start_write = 1'b1; addr_full = 32'h1008; start_count = 16'd12;
        beat_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R6", "stalled valid", beat_valid, 1);
            chk("R6", "stalled addr", beat_addr, 32'h1008);
            chk("R6", "stalled be", beat_be, 4'hF);
            @(negedge clk);
        end
        beat_ready = 1'b1;
        @(negedge clk);
        chk("R6", "addr after accept", beat_addr, 32'h100C);
        while (!done) @(negedge clk);
        beat_ready = 1'b0;
        @(negedge clk);

        // R8 start while busy is ignored
        run_region(1'b1, 32'h1000, 16'd32, 0, 2);
        chk("R8", "beats with mid-run start", n_beats, 8);
        chk("R8", "last addr with mid-run start", laddr, 32'h101C);
        chk("R8", "byte sum with mid-run start", byte_sum, 32);
        chk("R8", "idle after region", busy, 0);

        // R9 zero count means 65536 bytes
        run_region(1'b1, 32'h4000, 16'd0, 0, -1);
        chk("R9", "beats for zero count", n_beats, 16384);
        chk("R9", "bytes for zero count", byte_sum, 65536);
        chk("R5", "bursts for zero count", n_sop, 2048);
        chk("R9", "last addr for zero count", laddr, 32'h13FFC);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule